// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block generates four independent pulse-width-modulated outputs from one clock. Software programs it through a simple synchronous register port. A shared control register holds one run bit and one two-bit step-clock divider code for every channel. One configuration register per channel holds the period length and the high time, both counted in steps of that channel's divided clock. Each channel has its own divider chain and step counter. Each output is driven from a flip-flop.

The divider chain has two cascaded stages, one dividing by 8 and one by 64. A channel steps at the full clock rate, through either stage alone, or through both stages together for a ratio of 512. New period, high-time and divider values are held as pending until the running period ends. This means an output never shows a truncated or mixed period. Clearing a run bit stops its channel and drives the output low. Setting the bit again starts a new period from the first step.

Top module: `pwm4_top`

## Requirements
- R1: After synchronous reset, every register reads zero and every output is low.
- R2: A write happens when `bus_we` is high at a rising edge, and the word address is `bus_addr[7:2]`. Address 0x0 is the control register: bits 3:0 are the run bits of channels 0 to 3, and bits [2c+5:2c+4] hold channel c's divider code. Address 0x4+4c is channel c's configuration register: bits 7:0 hold the period length and bits 23:16 hold the high time.
- R3: `bus_rdata` is registered. After each rising edge it shows the register selected by `bus_addr` at that edge. Unused bits and unmapped addresses read as zero.
- R4: Suppose a run bit is written to 1 at edge E, with period length P, high time D and divider ratio N. After edge E+1+m the output equals 1 exactly when floor(m/N) mod P < D. The period is therefore P·N clocks and starts with its high part.
- R5: Divider code 0 selects a ratio of 1, code 1 selects 8, code 2 selects 64 and code 3 selects 512.
- R6: A high time of 0 keeps the output low for the whole period. A high time equal to or greater than the period length keeps it high for the whole period.
- R7: A period length of 0 keeps the output low while the channel runs.
- R8: A configuration write made while a channel runs has no effect until the period in progress ends. The new values apply from the first step of the next period.
- R9: Suppose a run bit is cleared at edge D. The output is low from edge D+1 onward. A later enable restarts the period from its first step.
- R10: Running, reconfiguring or stopping one channel does not change the output of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for registers and PWM counting |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pwm_out | output | 4 | PWM outputs, bit c belongs to channel c |

## Verification
The waveform is tested with several settings:
- A mid-range high time at ratio 1 checks the basic step timing and the phase at start-up.
- A high time of zero, one equal to the period, and one above the period check the saturated cases.
- A period length of zero checks the invalid case.
- One run at each divider code, each using a small period, separates the four ratios and shows the cascade at 512.
- A high-time change written part-way through a period tells deferred loading apart from immediate loading.
- A stop after every run shows the forced-low behaviour.
- A second channel held high while another toggles exposes any coupling between channels.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
  typedef enum logic [1:0] {
    STEP_DIV1   = 2'd0,
    STEP_DIV8   = 2'd1,
    STEP_DIV64  = 2'd2,
    STEP_DIV512 = 2'd3
  } step_div_e;

  localparam int unsigned DUTY_LSB = 16;
endpackage

// File: rtl/pwm4_regs.sv
module pwm4_regs
  import pwm4_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int TB_W   = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            we,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DATA_W-1:0]               wdata,
  output logic [DATA_W-1:0]               rdata,
  output logic [NUM_CH-1:0]               en_o,
  output logic [NUM_CH-1:0][1:0]          code_o,
  output logic [NUM_CH-1:0][TB_W-1:0]     tb_o,
  output logic [NUM_CH-1:0][TB_W-1:0]     duty_o
);
  localparam int IDX_W    = ADDR_W - 2;
  localparam int CODE_LSB = NUM_CH;

  logic [IDX_W-1:0]  widx;
  logic [DATA_W-1:0] rd_mux;

  assign widx = addr[ADDR_W-1:2];

  always_comb begin
    rd_mux = '0;
    if (widx == '0) begin
      rd_mux[NUM_CH-1:0] = en_o;
      for (int c = 0; c < NUM_CH; c++)
        rd_mux[2*c+CODE_LSB +: 2] = code_o[c];
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (widx == IDX_W'(c + 1)) begin
        rd_mux[TB_W-1:0]         = tb_o[c];
        rd_mux[DUTY_LSB +: TB_W] = duty_o[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o   <= '0;
      code_o <= '0;
      tb_o   <= '0;
      duty_o <= '0;
      rdata  <= '0;
    end else begin
      if (we) begin
        if (widx == '0) begin
          en_o <= wdata[NUM_CH-1:0];
          for (int c = 0; c < NUM_CH; c++)
            code_o[c] <= wdata[2*c+CODE_LSB +: 2];
        end
        for (int c = 0; c < NUM_CH; c++) begin
          if (widx == IDX_W'(c + 1)) begin
            tb_o[c]   <= wdata[TB_W-1:0];
            duty_o[c] <= wdata[DUTY_LSB +: TB_W];
          end
        end
      end
      rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/pwm4_prescaler.sv
module pwm4_prescaler
  import pwm4_pkg::*;
#(
  parameter int S0_W = 3,
  parameter int S1_W = 6
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      clr,
  input  step_div_e code,
  output logic      tick
);
  logic [S0_W-1:0] s0_q;
  logic [S1_W-1:0] s1_q;
  logic            s0_full, s1_full, s1_adv;

  assign s0_full = &s0_q;
  assign s1_full = &s1_q;
  // the second stage follows the first only when both are chained
  assign s1_adv  = (code == STEP_DIV512) ? s0_full : 1'b1;

  always_comb begin
    unique case (code)
      STEP_DIV1:   tick = 1'b1;
      STEP_DIV8:   tick = s0_full;
      STEP_DIV64:  tick = s1_full;
      STEP_DIV512: tick = s0_full & s1_full;
      default:     tick = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      s0_q <= '0;
      s1_q <= '0;
    end else begin
      s0_q <= s0_q + 1'b1;
      if (s1_adv) s1_q <= s1_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwm4_channel.sv
module pwm4_channel
  import pwm4_pkg::*;
#(
  parameter int TB_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [1:0]      code_sh,
  input  logic [TB_W-1:0] tb_sh,
  input  logic [TB_W-1:0] duty_sh,
  output logic            out
);
  logic            run_q;
  logic [1:0]      code_act;
  logic [TB_W-1:0] tb_act, duty_act, cnt_q;
  logic [1:0]      code_eff;
  logic [TB_W-1:0] tb_eff, duty_eff;
  logic            tick, wrap, ps_clr;

  // first running cycle uses the pending values directly
  assign code_eff = run_q ? code_act : code_sh;
  assign tb_eff   = run_q ? tb_act   : tb_sh;
  assign duty_eff = run_q ? duty_act : duty_sh;
  assign wrap     = (tb_eff == '0) || (cnt_q == tb_eff - 1'b1);
  assign ps_clr   = ~en | (tick & wrap);

  pwm4_prescaler i_prescaler (
    .clk  (clk),
    .rst  (rst),
    .clr  (ps_clr),
    .code (step_div_e'(code_eff)),
    .tick (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      code_act <= '0;
      tb_act   <= '0;
      duty_act <= '0;
      cnt_q    <= '0;
      out      <= 1'b0;
    end else if (!en) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      out   <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (!run_q || (tick && wrap)) begin
        code_act <= code_sh;
        tb_act   <= tb_sh;
        duty_act <= duty_sh;
      end
      if (tick) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      out <= (tb_eff != '0) && (cnt_q < duty_eff);
    end
  end
endmodule

// File: rtl/pwm4_top.sv
module pwm4_top #(
  parameter int NUM_CH = 4,
  parameter int TB_W   = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  logic [NUM_CH-1:0]           ctrl_en;
  logic [NUM_CH-1:0][1:0]      ctrl_code;
  logic [NUM_CH-1:0][TB_W-1:0] cfg_tb, cfg_duty;

  pwm4_regs #(
    .NUM_CH(NUM_CH), .TB_W(TB_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) i_regs (
    .clk    (clk),
    .rst    (rst),
    .we     (bus_we),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .rdata  (bus_rdata),
    .en_o   (ctrl_en),
    .code_o (ctrl_code),
    .tb_o   (cfg_tb),
    .duty_o (cfg_duty)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm4_channel #(.TB_W(TB_W)) i_channel (
      .clk     (clk),
      .rst     (rst),
      .en      (ctrl_en[c]),
      .code_sh (ctrl_code[c]),
      .tb_sh   (cfg_tb[c]),
      .duty_sh (cfg_duty[c]),
      .out     (pwm_out[c])
    );
  end
endmodule

// File: rtl/pwm4_chk.sv
module pwm4_chk #(
  parameter int NUM_CH = 4,
  parameter int TB_W   = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        bus_we,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic [DATA_W-1:0]           bus_wdata,
  input logic [DATA_W-1:0]           bus_rdata,
  input logic [NUM_CH-1:0]           pwm_out,
  input logic [NUM_CH-1:0]           en,
  input logic [NUM_CH-1:0][TB_W-1:0] tb,
  input logic [NUM_CH-1:0][TB_W-1:0] duty
);
  localparam int HI_LSB = 16 + TB_W;

  p_ctrl_wr_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr[ADDR_W-1:2] == '0) |=> (en == $past(bus_wdata[NUM_CH-1:0])));

  p_rd_unused_r3: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DATA_W-1:HI_LSB] == '0);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    p_dis_low_r9: assert property (@(posedge clk) disable iff (rst)
      !en[c] |=> !pwm_out[c]);

    p_start_high_r4: assert property (@(posedge clk) disable iff (rst)
      ($rose(en[c]) && tb[c] != '0 && duty[c] != '0) |=> pwm_out[c]);
  end
endmodule

bind pwm4_top pwm4_chk #(
  .NUM_CH(NUM_CH), .TB_W(TB_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pwm_out   (pwm_out),
  .en        (ctrl_en),
  .tb        (cfg_tb),
  .duty      (cfg_duty)
);

// File: tb/test_pwm4_top.sv
module test_pwm4_top;
  localparam int NUM_CH = 4;
  localparam int TB_W   = 8;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic [NUM_CH-1:0] pwm_out;

  always #5 clk = ~clk;

  pwm4_top #(.NUM_CH(NUM_CH), .TB_W(TB_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_pwm4_top (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  typedef struct {
    logic [NUM_CH-1:0] exp;
    string             tag;
  } item_t;

  item_t       sbq[$];
  int          n_chk = 0;
  int          n_fail = 0;
  logic [11:0] ctrl_sh = '0;

  // monitor: one expected output vector per falling edge
  always @(negedge clk) begin : mon
    item_t it;
    if (sbq.size() > 0) begin
      it = sbq.pop_front();
      n_chk++;
      if (pwm_out !== it.exp) begin
        n_fail++;
        $display("FAIL %s: pwm_out actual=%b expected=%b", it.tag, pwm_out, it.exp);
      end
    end
  end

  task automatic check(input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp, input string tag);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    check(bus_rdata, exp, tag);
  endtask

  task automatic run_wave(input int ch, input int tb, input int duty, input int code,
                          input int ncyc, input int new_duty,
                          input logic [NUM_CH-1:0] others, input string tag);
    int    ratio;
    item_t it;
    ratio = 1 << (3 * code);
    wr(ADDR_W'(4 + 4 * ch), (DATA_W'(duty) << 16) | DATA_W'(tb));
    ctrl_sh[2*ch+4 +: 2] = 2'(code);
    ctrl_sh[ch] = 1'b0;
    wr('0, DATA_W'(ctrl_sh));
    ctrl_sh[ch] = 1'b1;
    wr('0, DATA_W'(ctrl_sh));           // enable lands at edge E
    it.tag = tag;
    it.exp = others;                    // after E: output not yet started
    sbq.push_back(it);
    for (int m = 0; m < ncyc; m++) begin
      int d;
      int step;
      d = (new_duty >= 0 && m >= tb * ratio) ? new_duty : duty;
      step = (tb == 0) ? 0 : (m / ratio) % tb;
      it.exp = others;
      it.exp[ch] = (tb != 0) && (step < d);
      sbq.push_back(it);
    end
    if (new_duty >= 0) begin
      repeat (3) @(posedge clk);
      wr(ADDR_W'(4 + 4 * ch), (DATA_W'(new_duty) << 16) | DATA_W'(tb));  // R8 mid-period
    end
    wait (sbq.size() == 0);
    ctrl_sh[ch] = 1'b0;
    wr('0, DATA_W'(ctrl_sh));           // disable at edge D
    @(negedge clk);
    @(negedge clk);                     // after D+1
    check(DATA_W'(pwm_out[ch]), '0, "R9 output low after disable");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R4: watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : drv
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1 reset state
    check(DATA_W'(pwm_out), '0, "R1 outputs after reset");
    rd_chk(8'h00, '0, "R1 control after reset");
    rd_chk(8'h04, '0, "R1 config0 after reset");
    rd_chk(8'h10, '0, "R1 config3 after reset");
    // R2 / R3 register map and readback masking
    wr(8'h00, 32'hFFFF_FFF0);
    rd_chk(8'h00, 32'h0000_0FF0, "R2 control fields");
    wr(8'h08, 32'hFFFF_FFFF);
    rd_chk(8'h08, 32'h00FF_00FF, "R3 config1 unused bits zero");
    rd_chk(8'h04, '0, "R2 config0 untouched by config1 write");
    rd_chk(8'h14, '0, "R3 unmapped address");
    wr(8'h00, '0);
    wr(8'h08, '0);
    rd_chk(8'h00, '0, "R2 control cleared");
    // R4 basic waveform
    run_wave(0, 10, 3, 0, 40, -1, 4'b0000, "R4 tb10 duty3");
    run_wave(2, 7, 1, 0, 21, -1, 4'b0000, "R4 tb7 duty1");
    // R6 saturated duty
    run_wave(1, 5, 0, 0, 20, -1, 4'b0000, "R6 duty0");
    run_wave(1, 5, 5, 0, 20, -1, 4'b0000, "R6 duty=tb");
    run_wave(1, 5, 9, 0, 20, -1, 4'b0000, "R6 duty>tb");
    // R5 divider ratios
    run_wave(2, 4, 1, 1, 72, -1, 4'b0000, "R5 div8");
    run_wave(3, 3, 2, 2, 200, -1, 4'b0000, "R5 div64");
    run_wave(0, 2, 1, 3, 1100, -1, 4'b0000, "R5 div512");
    // R7 timebase zero
    run_wave(3, 0, 4, 0, 30, -1, 4'b0000, "R7 tb0 low");
    // R8 deferred update
    run_wave(0, 10, 3, 0, 40, 7, 4'b0000, "R8 shadow duty");
    // R10 independence: ch1 held high while ch0 toggles
    wr(8'h08, (32'd9 << 16) | 32'd5);
    ctrl_sh[3:2] = '0;                 // ch1 divider code fields are bits 7:6
    ctrl_sh[7:6] = 2'b00;
    ctrl_sh[1] = 1'b1;
    wr('0, DATA_W'(ctrl_sh));
    repeat (3) @(posedge clk);
    run_wave(0, 6, 2, 0, 30, -1, 4'b0010, "R10 ch1 steady");
    @(negedge clk);
    check(DATA_W'(pwm_out[1]), 32'd1, "R10 ch1 unaffected by ch0 stop");
    ctrl_sh[1] = 1'b0;
    wr('0, DATA_W'(ctrl_sh));
    @(negedge clk);
    @(negedge clk);
    check(DATA_W'(pwm_out), '0, "R9 all low after final disable");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule